// File: doc/BRIEF.md
# Extended-Address Page Walker

This block turns a 32-bit linear address into a 36-bit physical address by reading paging entries from memory one at a time. A request carries the linear address together with snapshots of the page-base register (`cr3`) and the mode-control register (`cr4`). The walker captures all three when the request is accepted. It then steps a small state machine through the levels the mode requires, issuing one 64-bit read per level. The result is a physical address and a page-size code, or a fault flag with the level whose entry had its present bit clear.

With the address extension enabled, the walk starts in a four-entry pointer table that lies below 4 GB. It continues through a 512-entry directory of 8-byte entries. From there it either ends at a 2 MB frame or goes on to a 512-entry table of 8-byte entries that maps a 4 KB frame. With the extension disabled, a two-level walk over 4-byte entries applies, and an optional 4 MB large-page leaf is allowed. In that mode the top four physical bits are always zero. When both extension flags are set, the 36-bit scheme wins.

States:
- `W_IDLE`: waiting for a request.
- `W_PTR`: reading the pointer table.
- `W_DIR`: reading the directory.
- `W_TBL`: reading the table.
- `W_DONE`: holding the result.

Transitions:
- `W_IDLE` goes to `W_PTR` on an extended request, or to `W_DIR` on a legacy request.
- `W_PTR` goes to `W_DIR` when the entry is present, or to `W_DONE` on a fault.
- `W_DIR` goes to `W_TBL` when the entry points to a table. It goes to `W_DONE` on a large-page leaf or a fault.
- `W_TBL` goes to `W_DONE` when its read returns.
- `W_DONE` goes to `W_IDLE` when `rsp_ready` is high.

Top module: `pae_walker`

## Requirements
- R1: `req_ready` is high only in the idle state, which is also the state after reset. After reset, `rsp_valid` and `mem_req` are low. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and `req_ready` is low for the rest of that walk.
- R2: When `cr4` bit 5 is set, the first read goes to byte address {4'b0, cr3[31:5], lin[31:30], 3'b000}. That address is always below 4 GB.
- R3: In the extended mode, the directory read goes to {pointer_entry[35:12], lin[29:21], 3'b000}.
- R4: In the extended mode, when directory entry bit 7 is clear, the table read goes to {dir_entry[35:12], lin[20:12], 3'b000}. The result is {table_entry[35:12], lin[11:0]} with page-size code 0 (4 KB).
- R5: In the extended mode, when directory entry bit 7 is set, the walk ends after two reads. The result is {dir_entry[35:21], lin[20:0]} with page-size code 1 (2 MB).
- R6: When `cr4` bits 5 and 4 are both set, the extended walk of R2 to R5 is used, and page-size code 2 never appears.
- R7: When `cr4` bit 5 is clear, the directory read goes to {4'b0, cr3[31:12], lin[31:22], 2'b00}. The table read goes to {4'b0, dir_entry[31:12], lin[21:12], 2'b00}. The result is {4'b0, table_entry[31:12], lin[11:0]} with code 0.
- R8: When `cr4` bit 5 is clear and bit 4 is set, a present directory entry with bit 7 set is a 4 MB leaf: {4'b0, dir_entry[31:22], lin[21:0]}, code 2. When bit 4 is clear, directory bit 7 has no effect and the table read still occurs.
- R9: Bit 0 of every entry is the present bit. If it is clear, the walk stops and reports `rsp_fault`=1, `rsp_paddr`=0, `rsp_page_size`=0 and `rsp_fault_level` as 0 (pointer), 1 (directory) or 2 (table).
- R10: At most one read is outstanding. `mem_req` stays high with `mem_addr` unchanged until `mem_rvalid` is sampled high.
- R11: `rsp_valid` and all result fields hold steady until `rsp_ready` is sampled high.
- R12: In the legacy mode, `mem_rdata[63:32]` is ignored and `rsp_paddr[35:32]` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_lin | input | 32 | Linear address to translate |
| req_cr3 | input | 32 | Page-base register snapshot |
| req_cr4 | input | 32 | Mode register snapshot (bit 5 extended, bit 4 large-page) |
| mem_req | output | 1 | Entry read requested |
| mem_addr | output | 36 | Byte address of the entry |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 64 | Entry read data |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_paddr | output | 36 | Translated physical address |
| rsp_page_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 4 MB |
| rsp_fault | output | 1 | An entry was not present |
| rsp_fault_level | output | 2 | 0 pointer, 1 directory, 2 table |

## Verification
Several properties are checked by assertions on every cycle:
- the two handshakes hold their values;
- the pointer-table read stays below 4 GB;
- the legacy mode never produces a nonzero top nibble;
- a fault reports a zero address;
- the extended mode never reports a 4 MB page.

The scenarios cover what a single cycle cannot show. They check the exact entry address at each level and the frame and offset splice for each page size. They also confirm that PS is ignored in the legacy mode without the large-page flag, that the extended mode takes precedence, and that a fault stops the walk at each of the three levels.

// File: rtl/pae_walk_pkg.sv
package pae_walk_pkg;
    localparam int LA_W   = 32;
    localparam int PA_W   = 36;
    localparam int ENT_W  = 64;
    localparam int PG_SH  = 12;
    localparam int FN_W   = PA_W - PG_SH;
    localparam int HI_W   = PA_W - LA_W;

    typedef enum logic [2:0] {
        W_IDLE, W_PTR, W_DIR, W_TBL, W_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        LVL_PTR = 2'd0, LVL_DIR = 2'd1, LVL_TBL = 2'd2
    } walk_lvl_e;

    typedef enum logic [1:0] {
        PG_4K = 2'd0, PG_2M = 2'd1, PG_4M = 2'd2
    } pg_size_e;
endpackage

// File: rtl/pw_entry_addr.sv
module pw_entry_addr
    import pae_walk_pkg::*;
(
    input  walk_state_e          st,
    input  logic                 ext,
    input  logic [LA_W-1:0]      lin,
    input  logic [LA_W-1:0]      cr3,
    input  logic [FN_W-1:0]      base_fn,
    output logic [PA_W-1:0]      addr
);
    always_comb begin
        case (st)
            W_PTR:   addr = {{HI_W{1'b0}}, cr3[31:5], lin[31:30], 3'b000};
            W_DIR:   addr = ext ? {base_fn, lin[29:21], 3'b000}
                                : {{HI_W{1'b0}}, cr3[31:12], lin[31:22], 2'b00};
            W_TBL:   addr = ext ? {base_fn, lin[20:12], 3'b000}
                                : {base_fn, lin[21:12], 2'b00};
            default: addr = '0;
        endcase
    end
endmodule

// File: rtl/pw_leaf_compose.sv
module pw_leaf_compose
    import pae_walk_pkg::*;
(
    input  logic                 ext,
    input  logic                 at_tbl,
    input  logic [ENT_W-1:0]     ent,
    input  logic [LA_W-1:0]      lin,
    output logic [PA_W-1:0]      paddr,
    output pg_size_e             size
);
    always_comb begin
        if (at_tbl) begin
            paddr = {ent[PA_W-1:12], lin[11:0]};
            size  = PG_4K;
        end else if (ext) begin
            paddr = {ent[PA_W-1:21], lin[20:0]};
            size  = PG_2M;
        end else begin
            paddr = {ent[PA_W-1:22], lin[21:0]};
            size  = PG_4M;
        end
    end
endmodule

// File: rtl/pae_walker.sv
module pae_walker
    import pae_walk_pkg::*;
#(
    parameter int EXT_BIT = 5,
    parameter int LPG_BIT = 4,
    parameter int PS_BIT  = 7,
    parameter int P_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_lin,
    input  logic [31:0]       req_cr3,
    input  logic [31:0]       req_cr4,
    output logic              mem_req,
    output logic [35:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [35:0]       rsp_paddr,
    output logic [1:0]        rsp_page_size,
    output logic              rsp_fault,
    output logic [1:0]        rsp_fault_level
);
    localparam int HALF_W = ENT_W / 2;

    walk_state_e        state_q, state_d;
    logic [LA_W-1:0]    lin_q, cr3_q;
    logic               pae_q, pse_q;
    logic [FN_W-1:0]    base_q;
    logic [PA_W-1:0]    paddr_q;
    pg_size_e           size_q;
    logic               fault_q;
    walk_lvl_e          lvl_q;

    logic [ENT_W-1:0]   ent_n;
    logic               present, large_leaf, in_fetch, take_req;
    logic [PA_W-1:0]    leaf_paddr, addr_w;
    pg_size_e           leaf_size;
    walk_lvl_e          cur_lvl;

    // legacy entries are 32 bits wide: drop the upper half
    assign ent_n      = pae_q ? mem_rdata : {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};
    assign present    = ent_n[P_BIT];
    assign large_leaf = (state_q == W_DIR) && ent_n[PS_BIT] && (pae_q || pse_q);
    assign in_fetch   = (state_q == W_PTR) || (state_q == W_DIR) || (state_q == W_TBL);
    assign take_req   = (state_q == W_IDLE) && req_valid;

    always_comb begin
        case (state_q)
            W_PTR:   cur_lvl = LVL_PTR;
            W_DIR:   cur_lvl = LVL_DIR;
            default: cur_lvl = LVL_TBL;
        endcase
    end

    pw_entry_addr u_addr (
        .st      (state_q),
        .ext     (pae_q),
        .lin     (lin_q),
        .cr3     (cr3_q),
        .base_fn (base_q),
        .addr    (addr_w)
    );

    pw_leaf_compose u_leaf (
        .ext     (pae_q),
        .at_tbl  (state_q == W_TBL),
        .ent     (ent_n),
        .lin     (lin_q),
        .paddr   (leaf_paddr),
        .size    (leaf_size)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE: if (req_valid)  state_d = req_cr4[EXT_BIT] ? W_PTR : W_DIR;
            W_PTR:  if (mem_rvalid) state_d = present ? W_DIR : W_DONE;
            W_DIR:  if (mem_rvalid) state_d = (!present || large_leaf) ? W_DONE : W_TBL;
            W_TBL:  if (mem_rvalid) state_d = W_DONE;
            W_DONE: if (rsp_ready)  state_d = W_IDLE;
            default:                state_d = W_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    // walk context and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_q   <= '0;
            cr3_q   <= '0;
            pae_q   <= 1'b0;
            pse_q   <= 1'b0;
            base_q  <= '0;
            paddr_q <= '0;
            size_q  <= PG_4K;
            fault_q <= 1'b0;
            lvl_q   <= LVL_PTR;
        end else if (take_req) begin
            lin_q   <= req_lin;
            cr3_q   <= req_cr3;
            pae_q   <= req_cr4[EXT_BIT];
            pse_q   <= req_cr4[LPG_BIT];
            fault_q <= 1'b0;
            lvl_q   <= LVL_PTR;
        end else if (in_fetch && mem_rvalid) begin
            base_q <= ent_n[PA_W-1:PG_SH];
            if (!present) begin
                fault_q <= 1'b1;
                lvl_q   <= cur_lvl;
                paddr_q <= '0;
                size_q  <= PG_4K;
            end else if ((state_q == W_TBL) || large_leaf) begin
                paddr_q <= leaf_paddr;
                size_q  <= leaf_size;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready       = (state_q == W_IDLE);
        mem_req         = in_fetch;
        mem_addr        = addr_w;
        rsp_valid       = (state_q == W_DONE);
        rsp_paddr       = paddr_q;
        rsp_page_size   = size_q;
        rsp_fault       = fault_q;
        rsp_fault_level = lvl_q;
    end
endmodule

// File: rtl/pae_walker_chk.sv
module pae_walker_chk
    import pae_walk_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        mem_req,
    input logic [35:0] mem_addr,
    input logic        mem_rvalid,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [35:0] rsp_paddr,
    input logic [1:0]  rsp_page_size,
    input logic        rsp_fault,
    input logic [1:0]  rsp_fault_level,
    input walk_state_e state_q,
    input logic        pae_q
);
    p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !rsp_valid));

    p_ptr_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_PTR) |-> (mem_addr[35:32] == 4'h0));

    p_ext_no_4m_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && pae_q) |-> (rsp_page_size != 2'd2));

    p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_fault_level != 2'd3));

    p_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
            && $stable(rsp_page_size) && $stable(rsp_fault) && $stable(rsp_fault_level)));

    p_legacy_hi_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !pae_q) |-> (rsp_paddr[35:32] == 4'h0));
endmodule

bind pae_walker pae_walker_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_ready       (req_ready),
    .mem_req         (mem_req),
    .mem_addr        (mem_addr),
    .mem_rvalid      (mem_rvalid),
    .rsp_valid       (rsp_valid),
    .rsp_ready       (rsp_ready),
    .rsp_paddr       (rsp_paddr),
    .rsp_page_size   (rsp_page_size),
    .rsp_fault       (rsp_fault),
    .rsp_fault_level (rsp_fault_level),
    .state_q         (state_q),
    .pae_q           (pae_q)
);

// File: tb/tb_pae_walker.sv
module tb_pae_walker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_lin, req_cr3, req_cr4;
    logic        mem_req;
    logic [35:0] mem_addr;
    logic        mem_rvalid;
    logic [63:0] mem_rdata;
    logic        rsp_valid;
    logic        rsp_ready;
    logic [35:0] rsp_paddr;
    logic [1:0]  rsp_page_size;
    logic        rsp_fault;
    logic [1:0]  rsp_fault_level;

    always #4 clk = ~clk;

    pae_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_lin(req_lin), .req_cr3(req_cr3), .req_cr4(req_cr4),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_page_size(rsp_page_size),
        .rsp_fault(rsp_fault), .rsp_fault_level(rsp_fault_level)
    );

    typedef struct {
        logic [35:0] paddr;
        logic [1:0]  size;
        logic        fault;
        logic [1:0]  lvl;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [63:0] mem_img [logic [35:0]];
    int          n_chk = 0;
    int          n_err = 0;
    bit          done  = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // memory responder, also watches R10 address stability
    int          wait_cnt = 0;
    int          lat = 1;
    int          nreads = 0;
    logic [35:0] held_addr;
    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        held_addr  = '0;
        forever begin
            @(posedge clk); #2;
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
                wait_cnt   = 0;
            end else if (mem_req) begin
                if (wait_cnt == 0) held_addr = mem_addr;
                else chk(mem_addr == held_addr, "R10 addr stable", 64'(mem_addr), 64'(held_addr));
                if (wait_cnt >= lat) begin
                    mem_rdata  = mem_img.exists(mem_addr) ? mem_img[mem_addr] : 64'h0;
                    mem_rvalid = 1'b1;
                    nreads++;
                    lat = nreads % 3;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid && rsp_ready) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R1 unexpected response", 64'(rsp_paddr), 64'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(rsp_fault == e.fault, {e.tag, " fault"}, 64'(rsp_fault), 64'(e.fault));
                chk(rsp_paddr == e.paddr, {e.tag, " paddr"}, 64'(rsp_paddr), 64'(e.paddr));
                chk(rsp_page_size == e.size, {e.tag, " size"}, 64'(rsp_page_size), 64'(e.size));
                if (e.fault)
                    chk(rsp_fault_level == e.lvl, {e.tag, " level"}, 64'(rsp_fault_level), 64'(e.lvl));
            end
        end
    end

    // driver: builds memory image and expected result from the requirements
    task automatic run_walk(input logic [31:0] lin, input logic [31:0] cr3, input logic [31:0] cr4,
                            input logic [63:0] e0, input logic [63:0] e1, input logic [63:0] e2,
                            input int hold, input string tag);
        exp_t        x;
        logic [35:0] a0, a1, a2;
        logic [31:0] w1, w2;
        mem_img.delete();
        x.tag = tag; x.fault = 1'b0; x.lvl = 2'd0; x.paddr = '0; x.size = 2'd0;
        if (cr4[5]) begin
            a0 = {4'h0, cr3[31:5], lin[31:30], 3'b000};
            mem_img[a0] = e0;
            if (!e0[0]) begin x.fault = 1'b1; x.lvl = 2'd0; end
            else begin
                a1 = {e0[35:12], lin[29:21], 3'b000};
                mem_img[a1] = e1;
                if (!e1[0]) begin x.fault = 1'b1; x.lvl = 2'd1; end
                else if (e1[7]) begin x.paddr = {e1[35:21], lin[20:0]}; x.size = 2'd1; end
                else begin
                    a2 = {e1[35:12], lin[20:12], 3'b000};
                    mem_img[a2] = e2;
                    if (!e2[0]) begin x.fault = 1'b1; x.lvl = 2'd2; end
                    else x.paddr = {e2[35:12], lin[11:0]};
                end
            end
        end else begin
            a1 = {4'h0, cr3[31:12], lin[31:22], 2'b00};
            mem_img[a1] = e1;
            w1 = e1[31:0];
            if (!w1[0]) begin x.fault = 1'b1; x.lvl = 2'd1; end
            else if (cr4[4] && w1[7]) begin x.paddr = {4'h0, w1[31:22], lin[21:0]}; x.size = 2'd2; end
            else begin
                a2 = {4'h0, w1[31:12], lin[21:12], 2'b00};
                mem_img[a2] = e2;
                w2 = e2[31:0];
                if (!w2[0]) begin x.fault = 1'b1; x.lvl = 2'd2; end
                else x.paddr = {4'h0, w2[31:12], lin[11:0]};
            end
        end
        sb_q.push_back(x);
        if (hold > 0) rsp_ready = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #2;
        req_valid = 1'b1; req_lin = lin; req_cr3 = cr3; req_cr4 = cr4;
        @(posedge clk); #2;
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {tag, " R1 busy"}, 64'(req_ready), 64'h0);
        if (hold > 0) begin
            @(negedge clk);
            while (!rsp_valid) @(negedge clk);
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                chk(rsp_valid == 1'b1, {tag, " R11 valid held"}, 64'(rsp_valid), 64'h1);
                chk(rsp_paddr == x.paddr, {tag, " R11 paddr held"}, 64'(rsp_paddr), 64'(x.paddr));
            end
            @(posedge clk); #2;
            rsp_ready = 1'b1;
        end
        wait (sb_q.size() == 0);
        @(posedge clk); #2;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 64'h0, 64'h1);
            report();
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_lin = '0; req_cr3 = '0; req_cr4 = '0;
        rsp_ready = 1'b1;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'h1);
        chk(rsp_valid == 1'b0, "R1 reset rsp_valid", 64'(rsp_valid), 64'h0);
        chk(mem_req == 1'b0, "R1 reset mem_req", 64'(mem_req), 64'h0);

        // R2 R3 R4: extended 4 KB walk
        run_walk(32'hC0A0_3ABC, 32'h0001_0020, 32'h20,
                 64'hFFF0_0000_5432_1001, 64'h0000_0007_89AB_C003, 64'h8000_000A_BCDE_F063, 0, "R4 ext 4K");
        // R5: extended 2 MB leaf
        run_walk(32'h4123_4567, 32'h0001_0020, 32'h20,
                 64'h0000_0002_0000_0001, 64'h0000_000F_FFE0_0083, 64'h0, 0, "R5 ext 2M");
        // R2 with a different pointer slot
        run_walk(32'h0000_0FFF, 32'hFFFF_FFE0, 32'h20,
                 64'h0000_000C_0000_0001, 64'h0000_0003_0000_0083, 64'h0, 0, "R2 ext slot0");
        // R9: faults at each level
        run_walk(32'h8000_1000, 32'h0001_0020, 32'h20,
                 64'h0000_0003_0000_0000, 64'h0, 64'h0, 0, "R9 fault ptr");
        run_walk(32'h8000_1000, 32'h0001_0020, 32'h20,
                 64'h0000_0003_0000_0001, 64'h0000_0004_0000_0080, 64'h0, 0, "R9 fault dir");
        run_walk(32'h8020_1000, 32'h0001_0020, 32'h20,
                 64'h0000_0003_0000_0001, 64'h0000_0004_0000_0001, 64'h0000_0001_2345_6000, 0, "R9 fault tbl");
        // R6: both flags set
        run_walk(32'hC0A0_3ABC, 32'h0001_0020, 32'h30,
                 64'h0000_0000_5432_1001, 64'h0000_0007_89AB_C003, 64'h0000_0009_1111_2001, 0, "R6 ext+lpg 4K");
        run_walk(32'h4123_4567, 32'h0001_0020, 32'h30,
                 64'h0000_0002_0000_0001, 64'h0000_0008_0060_0081, 64'h0, 0, "R6 ext+lpg 2M");
        // R7 R12: legacy 4 KB with upper halves set
        run_walk(32'h8765_4321, 32'h0020_0000, 32'h0,
                 64'h0, 64'hFFFF_FFFF_0030_0001, 64'hFFFF_FFFF_ABCD_E001, 0, "R7 R12 legacy 4K");
        // R8: legacy 4 MB leaf
        run_walk(32'h8765_4321, 32'h0020_0000, 32'h10,
                 64'h0, 64'hFFFF_FFFF_C040_0081, 64'h0, 0, "R8 R12 legacy 4M");
        // R8: PS ignored without large-page flag
        run_walk(32'h8765_4321, 32'h0020_0000, 32'h0,
                 64'h0, 64'h0000_0000_0050_0081, 64'h0000_0000_1234_5001, 0, "R8 ps ignored");
        // R9: legacy table fault
        run_walk(32'h1234_5678, 32'h0020_0000, 32'h0,
                 64'h0, 64'h0000_0000_0030_0001, 64'hFFFF_FFFF_0000_0000, 0, "R9 legacy tbl");
        // R11: result held while consumer stalls
        run_walk(32'h4123_4567, 32'h0001_0020, 32'h20,
                 64'h0000_0002_0000_0001, 64'h0000_000F_FFE0_0083, 64'h0, 5, "R11 hold");

        done = 1'b1;
        report();
    end
endmodule